// File: doc/BRIEF.md
# Eight-Line Programmable Interrupt Controller

This block gathers eight interrupt request lines and tells a processor which one to service. It is programmed through a byte-wide write port with two addresses: a command address and a data address. Writing a start word to the command address begins an initialization run. The next words on the data address are decoded by their position in that run: first the vector base, then a cascade word if the controller is part of a chain, then a mode word if the start word asked for one. After the run completes, each data-address write loads the mask register.

Once running, the controller latches rising edges on its inputs. It drops the masked lines and the lines already in service. It then picks the lowest-numbered remaining line and raises its interrupt output, but only if that line outranks every line currently in service. An acknowledge pulse moves the winner into the in-service set and presents the base plus the line number on the vector output. An end-of-interrupt command on the command address retires the most urgent in-service line.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset the interrupt output is 0, the vector output is 0x00 and the controller is outside the running state.
- R2: A command-address write with bit 4 set starts initialization. It clears the mask register, all latched requests and all in-service bits. Its bit 1 = 1 means no chain (single mode), and its bit 0 = 1 means a mode word will follow.
- R3: After the start word, data writes are taken in order as base, then the cascade word (skipped in single mode), then the mode word (skipped when start-word bit 0 is 0). The controller is running after the last of these words.
- R4: On a granted acknowledge, the vector output, one cycle later, equals data bits 7:3 of the base word followed by the 3-bit line number. A base of 0x20 and line 3 give 0x23.
- R5: Until initialization completes, the interrupt output stays 0 and data-address writes leave the mask register unchanged.
- R6: While running, a data-address write loads the 8-bit mask. Bit n = 1 blocks line n, so 0x00 enables all lines and 0xFF blocks all lines.
- R7: A 0-to-1 transition on line n latches a request for line n. A line held high produces no further request after it has been served.
- R8: The interrupt output is high while running when there is a latched, unmasked, not-in-service line whose number is below every in-service line. The lowest such line is the winner.
- R9: An acknowledge while the interrupt output is high sets the winner's in-service bit and clears its request. An acknowledge while the interrupt output is low changes nothing.
- R10: While running, a command-address write of 0x20 (bits 7:5 = 001, bits 4:3 = 00) clears the lowest-numbered in-service bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = command address, 1 = data address |
| wr_data | input | 8 | Write data byte |
| irq_in | input | 8 | Interrupt request lines, edge sensitive |
| ack | input | 1 | Acknowledge pulse from the processor |
| int_out | output | 1 | Interrupt output to the processor |
| vec_out | output | 8 | Vector of the last acknowledged line |

## Verification
An acknowledge and a fresh rising edge on a more urgent line can arrive in the same cycle. The bench asserts ack while raising line 1 with line 5 pending. It then expects vector 0x25 for the grant already decided, with the interrupt output high again at once for line 1, which now outranks the in-service line 5. A second acknowledge must yield 0x21, and an end-of-interrupt must retire line 1 rather than line 5, shown by line 7 staying blocked until a further end-of-interrupt.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int LINES   = 8;
    localparam int IDX_W   = $clog2(LINES);
    localparam int DATA_W  = 8;
    localparam int BASE_W  = DATA_W - IDX_W;

    // start-word bit positions
    localparam int START_BIT  = 4;
    localparam int SINGLE_BIT = 1;
    localparam int MODE_BIT   = 0;
    // end-of-interrupt code in bits 7:3
    localparam logic [4:0] EOI_CODE = 5'b00100;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_BASE,
        SEQ_CASC,
        SEQ_MODE,
        SEQ_RUN
    } seq_state_e;

    typedef struct packed {
        logic             found;
        logic [IDX_W-1:0] idx;
    } pick_t;

    // lowest set bit wins
    function automatic pick_t lowest_set(input logic [LINES-1:0] v);
        pick_t p;
        p = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.found = 1'b1;
                p.idx   = IDX_W'(i);
            end
        end
        return p;
    endfunction
endpackage

// File: rtl/irqc_seq.sv
module irqc_seq
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              running,
    output logic              init_pulse,
    output logic              eoi_pulse,
    output logic [BASE_W-1:0] base,
    output logic [LINES-1:0]  mask
);
    seq_state_e state;
    logic       single_mode;
    logic       want_mode;
    logic       cmd_wr;
    logic       dat_wr;

    assign cmd_wr     = wr_en && !wr_addr;
    assign dat_wr     = wr_en && wr_addr;
    assign running    = (state == SEQ_RUN);
    assign init_pulse = cmd_wr && wr_data[START_BIT];
    assign eoi_pulse  = cmd_wr && running && (wr_data[DATA_W-1:IDX_W] == EOI_CODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= SEQ_IDLE;
            single_mode <= 1'b0;
            want_mode   <= 1'b0;
            base        <= '0;
            mask        <= '0;
        end else if (init_pulse) begin
            state       <= SEQ_BASE;
            single_mode <= wr_data[SINGLE_BIT];
            want_mode   <= wr_data[MODE_BIT];
            mask        <= '0;
        end else if (dat_wr) begin
            unique case (state)
                SEQ_BASE: begin
                    base <= wr_data[DATA_W-1:IDX_W];
                    if (!single_mode)   state <= SEQ_CASC;
                    else if (want_mode) state <= SEQ_MODE;
                    else                state <= SEQ_RUN;
                end
                SEQ_CASC: state <= want_mode ? SEQ_MODE : SEQ_RUN;
                SEQ_MODE: state <= SEQ_RUN;
                SEQ_RUN:  mask  <= wr_data[LINES-1:0];
                default:  state <= state;
            endcase
        end
    end
endmodule

// File: rtl/irqc_req.sv
module irqc_req
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] irq_in,
    input  logic             clear_all,
    input  logic             take,
    input  logic [IDX_W-1:0] take_idx,
    output logic [LINES-1:0] req
);
    logic [LINES-1:0] prev;
    logic [LINES-1:0] rise;
    logic [LINES-1:0] drop;

    assign rise = irq_in & ~prev;

    for (genvar g = 0; g < LINES; g++) begin : g_drop
        assign drop[g] = take && (take_idx == IDX_W'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '0;
            req  <= '0;
        end else begin
            prev <= irq_in;
            if (clear_all) req <= '0;
            else           req <= (req & ~drop) | rise;
        end
    end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
    import irqc_pkg::*;
(
    input  logic [LINES-1:0] req,
    input  logic [LINES-1:0] mask,
    input  logic [LINES-1:0] isr,
    output logic             grant_ok,
    output logic [IDX_W-1:0] grant_idx,
    output logic [IDX_W-1:0] top_isr_idx,
    output logic             isr_any
);
    pick_t cand;
    pick_t busy;

    always_comb begin
        cand        = lowest_set(req & ~mask & ~isr);
        busy        = lowest_set(isr);
        grant_idx   = cand.idx;
        top_isr_idx = busy.idx;
        isr_any     = busy.found;
        grant_ok    = cand.found && (!busy.found || (cand.idx < busy.idx));
    end
endmodule

// File: rtl/irq_ctrl8.sv
module irq_ctrl8
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LINES-1:0]  irq_in,
    input  logic              ack,
    output logic              int_out,
    output logic [DATA_W-1:0] vec_out
);
    logic              running;
    logic              init_pulse;
    logic              eoi_pulse;
    logic [BASE_W-1:0] base;
    logic [LINES-1:0]  mask;
    logic [LINES-1:0]  req;
    logic [LINES-1:0]  isr;
    logic [LINES-1:0]  isr_next;
    logic              grant_ok;
    logic [IDX_W-1:0]  grant_idx;
    logic [IDX_W-1:0]  top_isr_idx;
    logic              isr_any;
    logic              take;

    irqc_seq seq_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .running(running), .init_pulse(init_pulse), .eoi_pulse(eoi_pulse),
        .base(base), .mask(mask)
    );

    irqc_req req_i (
        .clk(clk), .rst(rst), .irq_in(irq_in), .clear_all(init_pulse),
        .take(take), .take_idx(grant_idx), .req(req)
    );

    irqc_prio prio_i (
        .req(req), .mask(mask), .isr(isr), .grant_ok(grant_ok),
        .grant_idx(grant_idx), .top_isr_idx(top_isr_idx), .isr_any(isr_any)
    );

    assign int_out = running && grant_ok;
    assign take    = ack && int_out;

    always_comb begin
        isr_next = isr;
        if (eoi_pulse && isr_any) isr_next[top_isr_idx] = 1'b0;
        if (take)                 isr_next[grant_idx]   = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr     <= '0;
            vec_out <= '0;
        end else begin
            isr <= init_pulse ? '0 : isr_next;
            if (take) vec_out <= {base, grant_idx};
        end
    end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              wr_addr,
    input logic              ack,
    input logic              int_out,
    input logic [DATA_W-1:0] vec_out,
    input logic              running,
    input logic              init_pulse,
    input logic              eoi_pulse,
    input logic [LINES-1:0]  mask,
    input logic [LINES-1:0]  req,
    input logic [LINES-1:0]  isr,
    input logic [IDX_W-1:0]  grant_idx
);
    assert_start_clears_R2: assert property (@(posedge clk) disable iff (rst)
        init_pulse |=> (mask == '0) && (isr == '0) && (req == '0));

    assert_mask_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        (!running && wr_en && wr_addr && !init_pulse) |=> $stable(mask));

    assert_int_needs_unmasked_R8: assert property (@(posedge clk) disable iff (rst)
        int_out |-> ((req & ~mask & ~isr) != '0));

    assert_grant_to_service_R9: assert property (@(posedge clk) disable iff (rst)
        (ack && int_out && !init_pulse) |=>
            isr[$past(grant_idx)] && (vec_out[IDX_W-1:0] == $past(grant_idx)));

    assert_eoi_retires_one_R10: assert property (@(posedge clk) disable iff (rst)
        (eoi_pulse && !(ack && int_out) && (isr != '0)) |=>
            ($countones(isr) + 1 == $countones($past(isr))));
endmodule

bind irq_ctrl8 irqc_checker chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .ack(ack),
    .int_out(int_out), .vec_out(vec_out), .running(running),
    .init_pulse(init_pulse), .eoi_pulse(eoi_pulse), .mask(mask),
    .req(req), .isr(isr), .grant_idx(grant_idx)
);

// File: tb/irq_ctrl8_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl8_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] irq_in = '0;
    logic       ack = 1'b0;
    logic       int_out;
    logic [7:0] vec_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_ctrl8 dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq_in(irq_in), .ack(ack), .int_out(int_out), .vec_out(vec_out)
    );

    task automatic check(input string req_tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req_tag, actual, expected);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse(input int line);
        @(negedge clk); irq_in[line] = 1'b1;
        @(negedge clk); irq_in[line] = 1'b0;
    endtask

    task automatic do_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic eoi(); wr(1'b0, 8'h20); endtask

    task automatic t_reset();
        check("R1 int after reset", int_out, 0);
        check("R1 vec after reset", vec_out, 8'h00);
        pulse(0);
        check("R1 not running after reset", int_out, 0);
    endtask

    task automatic t_init_master();
        wr(1'b0, 8'h11);
        pulse(0);
        check("R5 int low in init", int_out, 0);
        wr(1'b1, 8'h20);
        wr(1'b1, 8'hFF);            // cascade word, must not reach mask
        check("R5 int low before mode word", int_out, 0);
        wr(1'b1, 8'h01);
        check("R3 running after mode word, R5 mask untouched", int_out, 1);
        do_ack();
        check("R4 vector line 0", vec_out, 8'h20);
        eoi();
        check("R10 idle after eoi", int_out, 0);
    endtask

    task automatic t_line3();
        pulse(3);
        check("R7 edge latched line 3", int_out, 1);
        do_ack();
        check("R4 vector line 3", vec_out, 8'h23);
        check("R9 request cleared by ack", int_out, 0);
        eoi();
    endtask

    task automatic t_held_level();
        @(negedge clk); irq_in[4] = 1'b1;
        @(negedge clk);
        check("R7 rising edge line 4", int_out, 1);
        do_ack();
        check("R4 vector line 4", vec_out, 8'h24);
        eoi();
        check("R7 held level no repeat", int_out, 0);
        @(negedge clk); irq_in[4] = 1'b0;
    endtask

    task automatic t_mask();
        wr(1'b1, 8'h08);
        pulse(3);
        check("R6 masked line 3 silent", int_out, 0);
        wr(1'b1, 8'h00);
        check("R6 unmask releases pending", int_out, 1);
        do_ack();
        check("R6 vector after unmask", vec_out, 8'h23);
        eoi();
        wr(1'b1, 8'hFF);
        pulse(6);
        check("R6 mask 0xFF blocks all", int_out, 0);
        wr(1'b1, 8'h00);
        do_ack();
        check("R6 pending line 6 served", vec_out, 8'h26);
        eoi();
    endtask

    task automatic t_preempt();
        pulse(6);
        pulse(2);
        do_ack();
        check("R8 lower line wins", vec_out, 8'h22);
        check("R8 line 6 blocked by in-service 2", int_out, 0);
        eoi();
        check("R10 eoi releases line 6", int_out, 1);
        do_ack();
        check("R8 line 6 served next", vec_out, 8'h26);
        eoi();
    endtask

    task automatic t_same_cycle();
        pulse(5);
        @(negedge clk); ack = 1'b1; irq_in[1] = 1'b1;
        @(negedge clk); ack = 1'b0; irq_in[1] = 1'b0;
        check("R9 ack grants line 5", vec_out, 8'h25);
        check("R8 line 1 outranks in-service 5", int_out, 1);
        do_ack();
        check("R4 nested vector line 1", vec_out, 8'h21);
        eoi();
        pulse(7);
        check("R10 eoi retired line 1 not 5", int_out, 0);
        eoi();
        check("R10 second eoi frees line 7", int_out, 1);
        do_ack();
        check("R4 vector line 7", vec_out, 8'h27);
        eoi();
    endtask

    task automatic t_ack_idle();
        do_ack();
        check("R9 ack ignored when idle", vec_out, 8'h27);
        check("R9 int stays low", int_out, 0);
    endtask

    task automatic t_single_mode();
        wr(1'b0, 8'h13);
        wr(1'b1, 8'h70);
        wr(1'b1, 8'h01);            // mode word, cascade skipped
        wr(1'b1, 8'h01);            // now the mask
        pulse(0);
        check("R3 single mode skips cascade", int_out, 0);
        pulse(1);
        do_ack();
        check("R4 base 0x70 line 1", vec_out, 8'h71);
        // line 1 left in service on purpose
    endtask

    task automatic t_no_mode_word();
        wr(1'b0, 8'h12);
        wr(1'b1, 8'h08);
        pulse(2);
        check("R2 in-service cleared by start, R3 running after base", int_out, 1);
        do_ack();
        check("R4 base 0x08 line 2", vec_out, 8'h0A);
        pulse(0);
        check("R2 mask cleared by start", int_out, 1);
        do_ack();
        check("R4 base 0x08 line 0", vec_out, 8'h08);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_init_master();
        t_line3();
        t_held_level();
        t_mask();
        t_preempt();
        t_same_cycle();
        t_ack_idle();
        t_single_mode();
        t_no_mode_word();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule